// File: doc/BRIEF.md
# Header-Embedded Timestamp Latency Meter

This block measures round-trip latency without storing anything per request. When a request leaves the egress stage, the block samples a free-running nanosecond counter. It splits that value across header fields that the device under test reflects back in its reply. The low slice goes into the transport source port. The middle slice goes into the low half of the source IP address, and the subnet prefix fills the high half. When DNS mode is on, the high slice goes into the transaction identifier.

When a reply reaches ingress, the counter is sampled again. The transmit time is rebuilt from the reflected fields: the destination port, the low half of the destination IP, and the transaction identifier. The block then emits one latency sample with a single-cycle valid strobe. Header fields are presented as parallel inputs; parsing and checksum repair happen elsewhere.

The subtraction is modular at the compared width, so counter wraparound between request and reply still gives the right answer. Replies addressed outside the configured subnet are dropped silently.

Top module: `hts_latency_meter`

## Requirements
- R1: One cycle after `tx_valid`, `tx_src_port` equals bits [15:0] of `ts_now` sampled in the `tx_valid` cycle.
- R2: One cycle after `tx_valid`, `tx_src_ip_lo` equals bits [31:16] of that sampled `ts_now`, and `tx_src_ip_hi` equals `cfg_subnet`.
- R3: One cycle after `tx_valid`, `tx_txn_id` equals bits [47:32] of the sampled `ts_now` when `cfg_dns_en` is 1, and equals `tx_txn_id_in` when `cfg_dns_en` is 0.
- R4: `tx_out_valid` is 1 exactly in the cycle after each `tx_valid` cycle, and 0 otherwise.
- R5: With `cfg_dns_en` = 0 at the reply, `lat_ns[31:0]` = (`ts_now` − {`rx_dst_ip[15:0]`, `rx_dst_port`}) mod 2^32, and `lat_ns[47:32]` = 0. The transaction ID and the upper counter bits have no effect.
- R6: With `cfg_dns_en` = 1 at the reply, `lat_ns` = (`ts_now` − {`rx_txn_id`, `rx_dst_ip[15:0]`, `rx_dst_port`}) mod 2^48.
- R7: A reply whose receive time has wrapped past zero relative to the transmit time yields the true small difference.
- R8: A reply whose `rx_dst_ip[31:16]` differs from `cfg_subnet` produces no `lat_valid` pulse.
- R9: `lat_valid` is 1 exactly in the cycle after an `rx_valid` cycle whose subnet matches, and 0 in every other cycle.
- R10: In the cycle after reset is asserted, `lat_valid`, `tx_out_valid` and all output fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dns_en | input | 1 | Carry the high timestamp slice in the DNS transaction ID |
| cfg_subnet | input | 16 | Subnet prefix (IP high half) |
| ts_now | input | 48 | Free-running nanosecond counter |
| tx_valid | input | 1 | Request passes egress this cycle |
| tx_txn_id_in | input | 16 | Original transaction ID, kept when DNS mode is off |
| tx_out_valid | output | 1 | Rewritten request fields valid |
| tx_src_port | output | 16 | Transport source port to send |
| tx_src_ip_hi | output | 16 | Source IP high half to send |
| tx_src_ip_lo | output | 16 | Source IP low half to send |
| tx_txn_id | output | 16 | Transaction ID to send |
| rx_valid | input | 1 | Reply enters ingress this cycle |
| rx_dst_port | input | 16 | Reflected transport destination port |
| rx_dst_ip | input | 32 | Reflected destination IP address |
| rx_txn_id | input | 16 | Reflected transaction ID |
| lat_valid | output | 1 | Latency sample strobe |
| lat_ns | output | 48 | Latency in nanoseconds |

## Verification
Both paths have exactly one register stage. The rewritten request fields and `tx_out_valid` are due in the cycle after `tx_valid`. The latency sample and `lat_valid` are due in the cycle after `rx_valid`. The bench drives every stimulus on a falling edge and holds it across one rising edge. It samples the results at the next falling edge, then checks one more cycle to confirm that each strobe has dropped. Transmit times, delays and both modes are swept, including delays that cross the counter wrap, and the expected values are computed by modular arithmetic in the bench.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int HTS_FIELD_W_DEF = 16;
  localparam int HTS_NFIELDS     = 3;
  typedef enum logic {
    STAMP_SHORT = 1'b0,
    STAMP_LONG  = 1'b1
  } stamp_mode_e;
endpackage

// File: rtl/hts_tx_embed.sv
module hts_tx_embed #(
  parameter int FIELD_W = 16,
  localparam int TS_W = 3 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  hts_pkg::stamp_mode_e mode,
  input  logic [FIELD_W-1:0] subnet,
  input  logic [TS_W-1:0]    ts_egress,
  input  logic               fire,
  input  logic [FIELD_W-1:0] txn_in,
  output logic               out_valid,
  output logic [FIELD_W-1:0] port_q,
  output logic [FIELD_W-1:0] ip_hi_q,
  output logic [FIELD_W-1:0] ip_lo_q,
  output logic [FIELD_W-1:0] txn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      port_q    <= '0;
      ip_hi_q   <= '0;
      ip_lo_q   <= '0;
      txn_q     <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        port_q  <= ts_egress[FIELD_W-1:0];
        ip_lo_q <= ts_egress[2*FIELD_W-1:FIELD_W];
        ip_hi_q <= subnet;
        txn_q   <= (mode == hts_pkg::STAMP_LONG) ? ts_egress[TS_W-1:2*FIELD_W] : txn_in;
      end
    end
  end
endmodule

// File: rtl/hts_rx_rebuild.sv
module hts_rx_rebuild #(
  parameter int FIELD_W = 16,
  localparam int NF = hts_pkg::HTS_NFIELDS,
  localparam int TS_W = NF * FIELD_W
) (
  input  logic [FIELD_W-1:0]   subnet,
  input  logic [FIELD_W-1:0]   dst_port,
  input  logic [2*FIELD_W-1:0] dst_ip,
  input  logic [FIELD_W-1:0]   txn,
  output logic [TS_W-1:0]      tx_stamp,
  output logic                 in_subnet
);
  logic [FIELD_W-1:0] slice [NF];

  assign slice[0] = dst_port;
  assign slice[1] = dst_ip[FIELD_W-1:0];
  assign slice[2] = txn;

  for (genvar gi = 0; gi < NF; gi++) begin : g_slice
    assign tx_stamp[gi*FIELD_W +: FIELD_W] = slice[gi];
  end

  assign in_subnet = (dst_ip[2*FIELD_W-1:FIELD_W] == subnet);
endmodule

// File: rtl/hts_lat_calc.sv
module hts_lat_calc #(
  parameter int FIELD_W = 16,
  localparam int TS_W = 3 * FIELD_W,
  localparam int SHORT_W = 2 * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hts_pkg::stamp_mode_e mode,
  input  logic                 take,
  input  logic [TS_W-1:0]      rx_stamp,
  input  logic [TS_W-1:0]      tx_stamp,
  output logic                 lat_valid,
  output logic [TS_W-1:0]      lat
);
  logic [TS_W-1:0] diff;

  assign diff = rx_stamp - tx_stamp;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_valid <= 1'b0;
      lat       <= '0;
    end else begin
      lat_valid <= take;
      if (take) begin
        if (mode == hts_pkg::STAMP_LONG) lat <= diff;
        else lat <= {{(TS_W-SHORT_W){1'b0}}, diff[SHORT_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/hts_latency_meter.sv
module hts_latency_meter #(
  parameter int FIELD_W = hts_pkg::HTS_FIELD_W_DEF,
  localparam int TS_W = 3 * FIELD_W,
  localparam int IP_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_dns_en,
  input  logic [FIELD_W-1:0] cfg_subnet,
  input  logic [TS_W-1:0]    ts_now,
  input  logic               tx_valid,
  input  logic [FIELD_W-1:0] tx_txn_id_in,
  output logic               tx_out_valid,
  output logic [FIELD_W-1:0] tx_src_port,
  output logic [FIELD_W-1:0] tx_src_ip_hi,
  output logic [FIELD_W-1:0] tx_src_ip_lo,
  output logic [FIELD_W-1:0] tx_txn_id,
  input  logic               rx_valid,
  input  logic [FIELD_W-1:0] rx_dst_port,
  input  logic [IP_W-1:0]    rx_dst_ip,
  input  logic [FIELD_W-1:0] rx_txn_id,
  output logic               lat_valid,
  output logic [TS_W-1:0]    lat_ns
);
  hts_pkg::stamp_mode_e mode;
  logic [TS_W-1:0] rebuilt;
  logic            in_subnet;

  assign mode = cfg_dns_en ? hts_pkg::STAMP_LONG : hts_pkg::STAMP_SHORT;

  hts_tx_embed #(.FIELD_W(FIELD_W)) u_tx (
    .clk(clk), .rst(rst), .mode(mode), .subnet(cfg_subnet),
    .ts_egress(ts_now), .fire(tx_valid), .txn_in(tx_txn_id_in),
    .out_valid(tx_out_valid), .port_q(tx_src_port), .ip_hi_q(tx_src_ip_hi),
    .ip_lo_q(tx_src_ip_lo), .txn_q(tx_txn_id)
  );

  hts_rx_rebuild #(.FIELD_W(FIELD_W)) u_rx (
    .subnet(cfg_subnet), .dst_port(rx_dst_port), .dst_ip(rx_dst_ip),
    .txn(rx_txn_id), .tx_stamp(rebuilt), .in_subnet(in_subnet)
  );

  hts_lat_calc #(.FIELD_W(FIELD_W)) u_calc (
    .clk(clk), .rst(rst), .mode(mode), .take(rx_valid && in_subnet),
    .rx_stamp(ts_now), .tx_stamp(rebuilt), .lat_valid(lat_valid), .lat(lat_ns)
  );
endmodule

// File: rtl/hts_latency_meter_chk.sv
module hts_latency_meter_chk #(
  parameter int FIELD_W = 16,
  localparam int TS_W = 3 * FIELD_W,
  localparam int IP_W = 2 * FIELD_W
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_dns_en,
  input logic [FIELD_W-1:0] cfg_subnet,
  input logic [TS_W-1:0]    ts_now,
  input logic               tx_valid,
  input logic               tx_out_valid,
  input logic [FIELD_W-1:0] tx_src_port,
  input logic [FIELD_W-1:0] tx_src_ip_hi,
  input logic               rx_valid,
  input logic [IP_W-1:0]    rx_dst_ip,
  input logic               lat_valid,
  input logic [TS_W-1:0]    lat_ns
);
  AST_TX_PORT: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_src_port == $past(ts_now[FIELD_W-1:0])); // R1
  AST_TX_PREFIX: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_src_ip_hi == $past(cfg_subnet)); // R2
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
    tx_out_valid |-> $past(tx_valid)); // R4
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (lat_valid && !$past(cfg_dns_en)) |-> lat_ns[TS_W-1:IP_W] == '0); // R5
  AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_dst_ip[IP_W-1:FIELD_W] != cfg_subnet) |=> !lat_valid); // R8
  AST_SAMPLE_DUE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_dst_ip[IP_W-1:FIELD_W] == cfg_subnet) |=> lat_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    lat_valid |-> $past(rx_valid)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!lat_valid && !tx_out_valid)); // R10
endmodule

bind hts_latency_meter hts_latency_meter_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_dns_en(cfg_dns_en), .cfg_subnet(cfg_subnet),
  .ts_now(ts_now), .tx_valid(tx_valid), .tx_out_valid(tx_out_valid),
  .tx_src_port(tx_src_port), .tx_src_ip_hi(tx_src_ip_hi), .rx_valid(rx_valid),
  .rx_dst_ip(rx_dst_ip), .lat_valid(lat_valid), .lat_ns(lat_ns)
);

// File: tb/hts_latency_meter_bench.sv
module hts_latency_meter_bench;
  localparam int FW = 16;
  localparam int TW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_dns_en = 1'b0;
  logic [FW-1:0] cfg_subnet = 16'h0A2B;
  logic [TW-1:0] ts_now = '0;
  logic          tx_valid = 1'b0;
  logic [FW-1:0] tx_txn_id_in = 16'h5A5A;
  logic          tx_out_valid;
  logic [FW-1:0] tx_src_port, tx_src_ip_hi, tx_src_ip_lo, tx_txn_id;
  logic          rx_valid = 1'b0;
  logic [FW-1:0] rx_dst_port = '0;
  logic [31:0]   rx_dst_ip = '0;
  logic [FW-1:0] rx_txn_id = '0;
  logic          lat_valid;
  logic [TW-1:0] lat_ns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hts_latency_meter u_hts_latency_meter (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit dns, input logic [TW-1:0] t, input logic [TW-1:0] d, input logic [TW-1:0] junk);
    logic [FW-1:0] p, lo, tid;
    logic [TW-1:0] r, e;
    @(negedge clk);
    cfg_dns_en = dns; ts_now = t; tx_valid = 1'b1;
    tx_txn_id_in = t[15:0] ^ 16'hC3C3;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_out_valid == 1'b1, "R4", 64'(tx_out_valid), 64'd1);
    chk(tx_src_port == t[15:0], "R1", 64'(tx_src_port), 64'(t[15:0]));
    chk(tx_src_ip_lo == t[31:16] && tx_src_ip_hi == cfg_subnet, "R2",
        64'({tx_src_ip_hi, tx_src_ip_lo}), 64'({cfg_subnet, t[31:16]}));
    chk(tx_txn_id == (dns ? t[47:32] : (t[15:0] ^ 16'hC3C3)), "R3",
        64'(tx_txn_id), 64'(dns ? t[47:32] : (t[15:0] ^ 16'hC3C3)));
    p = tx_src_port; lo = tx_src_ip_lo; tid = tx_txn_id;
    @(negedge clk);
    chk(tx_out_valid == 1'b0, "R4", 64'(tx_out_valid), 64'd0);
    r = t + d + (dns ? 48'd0 : junk);
    rx_dst_port = p; rx_dst_ip = {cfg_subnet, lo};
    rx_txn_id = dns ? tid : (tid ^ junk[15:0]);
    ts_now = r; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    e = dns ? d : {16'h0, d[31:0]};
    chk(lat_valid == 1'b1, "R9", 64'(lat_valid), 64'd1);
    chk(lat_ns == e, dns ? "R6" : "R5", 64'(lat_ns), 64'(e));
    if (t + d < t || t[31:0] + d[31:0] < t[31:0])
      chk(lat_ns == e, "R7", 64'(lat_ns), 64'(e));
    @(negedge clk);
    chk(lat_valid == 1'b0, "R9", 64'(lat_valid), 64'd0);
  endtask

  initial begin
    logic [TW-1:0] tlist [6];
    logic [TW-1:0] dlist [6];
    tlist = '{48'h0, 48'h0000_0000_1234, 48'h0000_FFFF_FFF0, 48'hFFFF_FFFF_FFF8,
              48'h1234_5678_9ABC, 48'h7FFF_0000_FFFF};
    dlist = '{48'd0, 48'd1, 48'd17, 48'd65536, 48'd1_000_000, 48'h0001_0000_0003};
    repeat (3) @(negedge clk);
    chk(!lat_valid && !tx_out_valid && tx_src_port == 0 && lat_ns == 0, "R10",
        64'({lat_valid, tx_out_valid}), 64'd0);
    rst = 1'b0;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_case(m[0], tlist[i], (m == 0) ? {16'h0, dlist[j][31:0]} : dlist[j], 48'h4321_0000_0000);
    // R8: foreign subnet must not yield a sample
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rx_dst_ip = {cfg_subnet ^ (16'h1 << (k * 5)), 16'h0042};
      rx_valid = 1'b1; ts_now = 48'd999;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(lat_valid == 1'b0, "R8", 64'(lat_valid), 64'd0);
    end
    // R10: reset in mid-traffic clears outputs
    @(negedge clk);
    tx_valid = 1'b1; rx_valid = 1'b1; rx_dst_ip = {cfg_subnet, 16'h0};
    @(negedge clk);
    rst = 1'b1; tx_valid = 1'b0; rx_valid = 1'b0;
    @(negedge clk);
    chk(!lat_valid && !tx_out_valid && lat_ns == 0 && tx_txn_id == 0, "R10",
        64'({lat_valid, tx_out_valid}), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule